// File: doc/BRIEF.md
# Multiplexed Address/Data Read-Only Store Front End

This block models the front end of a byte-wide one-time-programmable store on a single clock. The low byte of the address and the returned data byte share one 8-bit bus. While the host holds the latch strobe high, the block samples that bus as the low address byte and stays in standby. When the strobe falls, the byte it held is kept. With the strobe low and the active-low output enable asserted, the block drives the stored byte at `{hiAddr, low byte}` back onto the bus. With output enable deasserted, it releases the bus.

An identification select stands in for the high-voltage pin condition. When it is set and every upper address bit except bit 0 is low, the block returns one of two fixed codes in place of array contents. The bus is brought out as a separate input, output and drive-enable, so a surrounding tristate pad or bench can merge them. A separate programming port writes the array. The array depth is set by `ARRAY_AW`: a value of 16 gives the full 65,536 bytes, and smaller values fold the upper address bits away.

Top module: `muxrom_front`

## Requirements
- R1: While `rstN` is low, `busDrive` and `dataValid` are 0. Reset clears the low-address latch to 0, so a read after reset with no latch strobe returns the byte at `{hiAddr, 8'h00}`.
- R2: On each clock edge where `latchStb` is 1, the latch takes `busIn`. On edges where `latchStb` is 0, the latch holds, and `busIn` has no effect on the address that is read.
- R3: With `latchStb` 0 and `outEnN` 0, `busOut` carries the array byte at `{hiAddr, latch}`, registered one clock after the address. The array index is the low `ARRAY_AW` bits of that address.
- R4: With `outEnN` 1 and `latchStb` 0, `busDrive` is 0 and `busOut` is 8'h00.
- R5: While `latchStb` is 1, `standby` is 1 and `busDrive` is 0, whatever the state of `outEnN`.
- R6: With `idMode` 1 and `hiAddr[7:1]` all 0, a read returns 8'h1E when `hiAddr[0]` is 0 and 8'h9D when `hiAddr[0]` is 1.
- R7: With `idMode` 1 but any of `hiAddr[7:1]` set, a read returns array contents as in R3.
- R8: `dataValid` is 1 on the clock after an edge at which `latchStb` is 0 and `outEnN` is 0. It is 0 on the clock after any edge at which either `latchStb` or `outEnN` is 1.
- R9: On an edge with `progEn` 1, `progData` is written to the array at `progAddr`, in any mode. A later read of that address returns the new byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| hiAddr | input | 8 | Upper address byte |
| busIn | input | 8 | Shared bus as seen by the block (low address byte when latching) |
| latchStb | input | 1 | Address latch strobe; high also means standby |
| outEnN | input | 1 | Active-low output enable |
| idMode | input | 1 | Identification select |
| progEn | input | 1 | Array write strobe |
| progAddr | input | 16 | Array write address |
| progData | input | 8 | Array write data |
| busOut | output | 8 | Byte driven toward the shared bus (0 when released) |
| busDrive | output | 1 | Drive enable for the shared bus |
| standby | output | 1 | Standby indication |
| dataValid | output | 1 | Registered flag: read data is on the bus |

## Verification
The bench changes `busIn` to junk right after the strobe falls. A latch that kept following the bus would then return the wrong byte. It reads straight after reset without latching, which catches a latch that comes out of reset at a nonzero value. It holds `outEnN` low while the strobe is high, which exposes a design that drives during standby. It also tries identification reads with one high upper bit set, where a decoder that tests bit 0 alone would return a code instead of array data. Finally, it moves `hiAddr` under a held latch and rewrites a location through the programming port, so a stale read register or a lost write shows up as a wrong byte.

// File: rtl/muxrom_pkg.sv
package muxrom_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic capLo;   // sample bus into low-address latch
    logic drive;   // drive the shared bus
    logic idSel;   // qualified identification read
  } muxrom_strobe_t;
endpackage

// File: rtl/muxrom_ctrl.sv
module muxrom_ctrl
  import muxrom_pkg::*;
#(
  parameter int HI_W = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            latchStb,
  input  logic            outEnN,
  input  logic            idMode,
  input  logic [HI_W-1:0] hiAddr,
  output muxrom_strobe_t  stb,
  output logic            standby,
  output logic            dataValid
);
  logic readReq;

  assign readReq   = !latchStb && !outEnN;
  assign standby   = latchStb;
  assign stb.capLo = latchStb;
  assign stb.drive = rstN && readReq;
  assign stb.idSel = idMode && ((hiAddr >> 1) == '0);

  always_ff @(posedge clk) begin
    if (!rstN) dataValid <= 1'b0;
    else       dataValid <= readReq;
  end

  // R1
  always_comb begin
    if (!rstN) reset_quiet_chk: assert (!stb.drive);
  end

  // R5
  standby_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    latchStb |-> !stb.drive);

  // R8
  valid_rise_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!latchStb && !outEnN) |=> dataValid);

  // R8
  valid_fall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (latchStb || outEnN) |=> !dataValid);
endmodule

// File: rtl/muxrom_datapath.sv
module muxrom_datapath
  import muxrom_pkg::*;
#(
  parameter int          HI_W     = 8,
  parameter int          LO_W     = 8,
  parameter int          ARRAY_AW = 12,
  parameter logic [LO_W-1:0] MFR_CODE = 8'h1E,
  parameter logic [LO_W-1:0] DEV_CODE = 8'h9D,
  localparam int         ADDR_W   = HI_W + LO_W,
  localparam int         DEPTH    = 1 << ARRAY_AW
) (
  input  logic              clk,
  input  logic              rstN,
  input  muxrom_strobe_t    stb,
  input  logic [HI_W-1:0]   hiAddr,
  input  logic [LO_W-1:0]   busIn,
  input  logic              progEn,
  input  logic [ADDR_W-1:0] progAddr,
  input  logic [LO_W-1:0]   progData,
  output logic [LO_W-1:0]   busOut
);
  logic [LO_W-1:0]     loLatch;
  logic [LO_W-1:0]     rdData;
  logic [ADDR_W-1:0]   fullAddr;
  logic [LO_W-1:0]     store [DEPTH];

  assign fullAddr = {hiAddr, loLatch};

  always_ff @(posedge clk) begin
    if (!rstN)          loLatch <= '0;
    else if (stb.capLo) loLatch <= busIn;
  end

  always_ff @(posedge clk) begin
    if (progEn) store[ARRAY_AW'(progAddr)] <= progData;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdData <= '0;
    else if (stb.idSel) rdData <= hiAddr[0] ? DEV_CODE : MFR_CODE;
    else                rdData <= store[ARRAY_AW'(fullAddr)];
  end

  assign busOut = stb.drive ? rdData : '0;

  // R2
  latch_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.capLo |=> loLatch == $past(busIn));

  // R2
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !stb.capLo |=> $stable(loLatch));

  // R6
  id_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.idSel && stb.drive) |=> (rdData == MFR_CODE || rdData == DEV_CODE));
endmodule

// File: rtl/muxrom_front.sv
module muxrom_front
  import muxrom_pkg::*;
#(
  parameter int HI_W     = 8,
  parameter int LO_W     = 8,
  parameter int ARRAY_AW = 12
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [HI_W-1:0]      hiAddr,
  input  logic [LO_W-1:0]      busIn,
  input  logic                 latchStb,
  input  logic                 outEnN,
  input  logic                 idMode,
  input  logic                 progEn,
  input  logic [HI_W+LO_W-1:0] progAddr,
  input  logic [LO_W-1:0]      progData,
  output logic [LO_W-1:0]      busOut,
  output logic                 busDrive,
  output logic                 standby,
  output logic                 dataValid
);
  muxrom_strobe_t stb;

  muxrom_ctrl #(.HI_W(HI_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .latchStb(latchStb), .outEnN(outEnN),
    .idMode(idMode), .hiAddr(hiAddr), .stb(stb),
    .standby(standby), .dataValid(dataValid)
  );

  muxrom_datapath #(.HI_W(HI_W), .LO_W(LO_W), .ARRAY_AW(ARRAY_AW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .hiAddr(hiAddr), .busIn(busIn),
    .progEn(progEn), .progAddr(progAddr), .progData(progData),
    .busOut(busOut)
  );

  assign busDrive = stb.drive;

  // R4
  released_chk: assert property (@(posedge clk) disable iff (!rstN)
    (outEnN && !latchStb) |-> (!busDrive && busOut == '0));
endmodule

// File: tb/muxrom_front_tb.sv
module muxrom_front_tb;
  localparam int AW = 12;
  localparam int DEPTH = 1 << AW;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [7:0] hiAddr = '0, busIn = '0, progData = '0;
  logic latchStb = 1'b0, outEnN = 1'b1, idMode = 1'b0, progEn = 1'b0;
  logic [15:0] progAddr = '0;
  logic [7:0] busOut;
  logic busDrive, standby, dataValid;

  logic [7:0] shadow [DEPTH];
  int checks = 0, errors = 0, cycles = 0;

  always #10 clk = ~clk;

  muxrom_front #(.ARRAY_AW(AW)) u_dut (
    .clk(clk), .rstN(rstN), .hiAddr(hiAddr), .busIn(busIn),
    .latchStb(latchStb), .outEnN(outEnN), .idMode(idMode),
    .progEn(progEn), .progAddr(progAddr), .progData(progData),
    .busOut(busOut), .busDrive(busDrive), .standby(standby),
    .dataValid(dataValid)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act %0d exp <100000", cycles);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  function automatic logic [7:0] fillPat(input int a);
    logic [15:0] v = 16'(a);
    return v[7:0] ^ {v[11:8], v[11:8]} ^ 8'h5A;
  endfunction

  function automatic logic [7:0] expByte(input logic [7:0] hi, input logic [7:0] lo,
                                         input logic idm);
    if (idm && hi[7:1] == 7'd0) return hi[0] ? 8'h9D : 8'h1E;
    return shadow[AW'({hi, lo})];
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act %h exp %h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  // Latch lo, then read; junk on the bus after the strobe falls (R2)
  task automatic doRead(input logic [7:0] hi, input logic [7:0] lo, input logic idm,
                        input string req);
    hiAddr = hi; idMode = idm; busIn = lo; latchStb = 1'b1; outEnN = 1'b1;
    step();
    latchStb = 1'b0; outEnN = 1'b0; busIn = 8'(~lo ^ $urandom);
    #1 chk({req, " drive"}, {7'd0, busDrive}, 8'd1);
    step();
    chk({req, " valid R8"}, {7'd0, dataValid}, 8'd1);
    chk(req, busOut, expByte(hi, lo, idm));
  endtask

  task automatic doProg(input logic [15:0] a, input logic [7:0] d);
    progEn = 1'b1; progAddr = a; progData = d;
    step();
    progEn = 1'b0;
    shadow[AW'(a)] = d;
  endtask

  initial begin
    void'($urandom(32'h1234abcd));
    // Fill the array during reset (R9: writes in any mode)
    latchStb = 1'b0; outEnN = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      progEn = 1'b1; progAddr = 16'(a); progData = fillPat(a);
      shadow[a] = fillPat(a);
      step();
      if (a == 3) begin
        chk("R1 drive in reset", {7'd0, busDrive}, 8'd0);
        chk("R1 valid in reset", {7'd0, dataValid}, 8'd0);
      end
    end
    progEn = 1'b0;
    rstN = 1'b1;
    // R1: latch cleared; read without strobe
    hiAddr = 8'h03; outEnN = 1'b0; latchStb = 1'b0;
    step();
    chk("R1 read after reset", busOut, shadow[12'h300]);

    // R4: output disable
    outEnN = 1'b1;
    #1 chk("R4 drive", {7'd0, busDrive}, 8'd0);
    chk("R4 bus", busOut, 8'h00);
    step();
    chk("R8 valid falls", {7'd0, dataValid}, 8'd0);

    // R5: standby with outEnN low
    latchStb = 1'b1; outEnN = 1'b0; busIn = 8'h44;
    #1 chk("R5 standby", {7'd0, standby}, 8'd1);
    chk("R5 drive", {7'd0, busDrive}, 8'd0);
    step();
    chk("R5 valid", {7'd0, dataValid}, 8'd0);
    chk("R5 bus", busOut, 8'h00);

    // R3 / R2 directed
    doRead(8'h0A, 8'hC3, 1'b0, "R3 read");
    doRead(8'hF7, 8'h12, 1'b0, "R3 fold read");
    // R3: hi changes under held latch
    hiAddr = 8'h05; busIn = 8'hFF;
    step();
    chk("R3 hi change", busOut, shadow[AW'({8'h05, 8'h12})]);
    chk("R2 hold", busOut, expByte(8'h05, 8'h12, 1'b0));

    // R6 / R7
    doRead(8'h00, 8'h77, 1'b1, "R6 mfr");
    chk("R6 mfr code", busOut, 8'h1E);
    doRead(8'h01, 8'h00, 1'b1, "R6 dev");
    chk("R6 dev code", busOut, 8'h9D);
    doRead(8'h03, 8'h21, 1'b1, "R7 unqualified");
    doRead(8'h80, 8'h21, 1'b1, "R7 unqualified top");

    // R9: rewrite then read
    doProg(16'h0A5C, 8'hE1);
    doRead(8'h0A, 8'h5C, 1'b0, "R9 rewrite");
    chk("R9 value", busOut, 8'hE1);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      logic [7:0] h, l;
      logic im;
      h = 8'($urandom);
      l = 8'($urandom);
      im = ($urandom % 8) == 0;
      if (im && ($urandom % 2)) h = {7'd0, h[0]};
      if (($urandom % 5) == 0) doProg({h, l}, 8'($urandom));
      doRead(h, l, im, im ? "R6/R7 random" : "R3 random");
      if (($urandom % 4) == 0) begin
        outEnN = 1'b1;
        step();
        chk("R8 random fall", {7'd0, dataValid}, 8'd0);
        chk("R4 random bus", busOut, 8'h00);
      end
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule